// File: doc/BRIEF.md
# Write Status Bit Generator

This block sits on the read path of a flash-style memory device. When the command decoder launches an internal word program or an erase, the block marks the device busy for a set number of clock cycles. While busy it replaces the read word with two status bits. Bit 7 is a polarity bit: it holds the inverse of bit 7 of the word being programmed, or a constant 0 during an erase. Bit 6 is a toggle bit that changes on every read access. Software polls these bits to learn when the operation has finished. When the busy interval ends, the block issues a one-cycle completion pulse so that the array commit can happen, and it returns to passing array read data through unchanged.

The busy length is set by three parameters, counted in clock cycles: one for word program, one shared by sector and block erase, and one for chip erase. A bench can therefore shorten them. The bits other than 7 and 6 come from a fixed parameter word while busy, so no array contents leak out.

The controller has three states. `ST_IDLE` passes array data through. `ST_PROG` reports program status. `ST_ERASE` reports erase status. It has four transitions:
- a start with a program code moves `ST_IDLE` to `ST_PROG`;
- a start with any erase code moves `ST_IDLE` to `ST_ERASE`;
- counter expiry moves `ST_PROG` back to `ST_IDLE`;
- counter expiry moves `ST_ERASE` back to `ST_IDLE`.

Top module: `wstat_gen`

## Requirements
- R1: After reset, `busy` and `op_done` are 0, `rd_data` equals `arr_rdata`, and the toggle bit holds `TGL_INIT` (default 0), which is seen on the first busy read.
- R2: A start pulse in idle raises `busy` in the next cycle. `busy` then stays high for exactly `PROG_CYC` cycles for `op_kind` 2'b00 (program), `SECT_CYC` cycles for 2'b01 (sector erase) and 2'b10 (block erase), and `CHIP_CYC` cycles for 2'b11 (chip erase).
- R3: `op_done` is high for exactly one cycle, the last cycle of the busy interval, and `busy` is low in the cycle after it.
- R4: A start pulse while busy is ignored: it neither extends the interval nor changes the operation type.
- R5: During a program, `rd_data[7]` is the inverse of `op_wdata[7]` as sampled with the start pulse. Later changes to `op_wdata` have no effect.
- R6: During any erase, `rd_data[7]` is 0.
- R7: While busy, `rd_data[6]` inverts after each cycle in which `rd_stb` is high, and holds in cycles without `rd_stb`.
- R8: The toggle bit is not reset between operations. Read strobes while idle do not change it.
- R9: While busy, every bit other than 7 and 6 equals the matching bit of parameter `FILL` (default 0), whatever the value of `arr_rdata`.
- R10: While not busy, `rd_data` equals `arr_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle start of an internal operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| op_wdata | input | DW | Word being programmed, sampled with the start pulse |
| rd_stb | input | 1 | One read access per high cycle |
| arr_rdata | input | DW | Array read data |
| busy | output | 1 | Internal operation in progress |
| op_done | output | 1 | One-cycle pulse on the last busy cycle |
| rd_data | output | DW | Read word: array data or status |

## Verification
On every cycle the assertions check the following:
- `op_done` occurs only while busy and is followed by idle;
- busy never drops before `op_done`;
- a start from idle always produces busy;
- the polarity bit right after a start matches the operation;
- the toggle bit flips or holds according to `rd_stb`.

Only the bench scenarios can show the exact interval lengths for each operation code. They also show that a start issued while busy is ignored, that the polarity bit stays latched while `op_wdata` changes, and that the toggle value carries across idle reads into the next operation.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'b00,
        OP_SECT  = 2'b01,
        OP_BLOCK = 2'b10,
        OP_CHIP  = 2'b11
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PROG  = 2'b01,
        ST_ERASE = 2'b10
    } wstat_state_t;

    localparam int POLL_POS = 7;
    localparam int TGL_POS  = 6;
endpackage

// File: rtl/wstat_timer.sv
module wstat_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/wstat_rdmux.sv
module wstat_rdmux
    import wstat_pkg::*;
#(
    parameter int          DW   = 16,
    parameter logic [DW-1:0] FILL = '0
) (
    input  logic          busy,
    input  logic          poll_bit,
    input  logic          tgl_bit,
    input  logic [DW-1:0] arr_rdata,
    output logic [DW-1:0] rd_data
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_POS) begin : g_poll
            assign rd_data[i] = busy ? poll_bit : arr_rdata[i];
        end else if (i == TGL_POS) begin : g_tgl
            assign rd_data[i] = busy ? tgl_bit : arr_rdata[i];
        end else begin : g_fill
            assign rd_data[i] = busy ? FILL[i] : arr_rdata[i];
        end
    end
endmodule

// File: rtl/wstat_gen.sv
module wstat_gen
    import wstat_pkg::*;
#(
    parameter int            DW       = 16,
    parameter int            PROG_CYC = 280,
    parameter int            SECT_CYC = 1800,
    parameter int            CHIP_CYC = 7000,
    parameter bit            TGL_INIT = 1'b0,
    parameter logic [DW-1:0] FILL     = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic [DW-1:0] op_wdata,
    input  logic          rd_stb,
    input  logic [DW-1:0] arr_rdata,
    output logic          busy,
    output logic          op_done,
    output logic [DW-1:0] rd_data
);
    localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    wstat_state_t  state_q, state_d;
    op_kind_t      kind;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expire;
    logic          poll_inv_q;
    logic          poll_bit;
    logic          tgl_q;

    assign kind = op_kind_t'(op_kind);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    state_d = (kind == OP_PROG) ? ST_PROG : ST_ERASE;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        busy     = 1'b0;
        op_done  = 1'b0;
        load     = 1'b0;
        poll_bit = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = op_start;
            end
            ST_PROG: begin
                busy     = 1'b1;
                op_done  = expire;
                poll_bit = poll_inv_q;
            end
            ST_ERASE: begin
                busy     = 1'b1;
                op_done  = expire;
                poll_bit = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (kind)
            OP_PROG:          load_val = CW'(PROG_CYC - 1);
            OP_SECT, OP_BLOCK: load_val = CW'(SECT_CYC - 1);
            OP_CHIP:          load_val = CW'(CHIP_CYC - 1);
            default:          load_val = CW'(PROG_CYC - 1);
        endcase
    end

    // polarity bit captured with the start pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_inv_q <= 1'b0;
        end else if (load) begin
            poll_inv_q <= ~op_wdata[POLL_POS];
        end
    end

    wstat_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .run      (busy),
        .expire   (expire)
    );

    wstat_toggle #(.INIT(TGL_INIT)) u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (busy && rd_stb),
        .q     (tgl_q)
    );

    wstat_rdmux #(.DW(DW), .FILL(FILL)) u_rdmux (
        .busy      (busy),
        .poll_bit  (poll_bit),
        .tgl_bit   (tgl_q),
        .arr_rdata (arr_rdata),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/wstat_gen_chk.sv
module wstat_gen_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_start,
    input logic [1:0]    op_kind,
    input logic [DW-1:0] op_wdata,
    input logic          rd_stb,
    input logic          busy,
    input logic          op_done,
    input logic [DW-1:0] rd_data
);
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> busy);  // R3
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !busy);  // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy);  // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy) |=> busy);  // R2
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && op_kind == 2'b00) |=> (rd_data[7] == !$past(op_wdata[7])));  // R5
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !busy && op_kind != 2'b00) |=> (rd_data[7] == 1'b0));  // R6
    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done && rd_stb) |=> (rd_data[6] != $past(rd_data[6])));  // R7
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done && !rd_stb) |=> $stable(rd_data[6]));  // R7
endmodule

bind wstat_gen wstat_gen_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_wdata (op_wdata),
    .rd_stb   (rd_stb),
    .busy     (busy),
    .op_done  (op_done),
    .rd_data  (rd_data)
);

// File: tb/wstat_gen_test.sv
module wstat_gen_test;
    localparam int DW = 16;
    localparam int PC = 5;
    localparam int SC = 9;
    localparam int CC = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic [1:0]    op_kind = 2'b00;
    logic [DW-1:0] op_wdata = '0;
    logic          rd_stb = 1'b0;
    logic [DW-1:0] arr_rdata = 16'hA5C3;
    logic          busy;
    logic          op_done;
    logic [DW-1:0] rd_data;

    int total = 0;
    int fails = 0;
    bit tgl_exp = 1'b0;

    always #4 clk = ~clk;

    wstat_gen #(.DW(DW), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_wdata(op_wdata), .rd_stb(rd_stb), .arr_rdata(arr_rdata),
        .busy(busy), .op_done(op_done), .rd_data(rd_data)
    );

    // {op_kind, op_wdata, expected busy cycles}
    localparam logic [25:0] VEC [6] = '{
        {2'b00, 16'h0080, 8'(PC)},
        {2'b00, 16'h1234, 8'(PC)},
        {2'b01, 16'hFFFF, 8'(SC)},
        {2'b10, 16'h0000, 8'(SC)},
        {2'b11, 16'h00FF, 8'(CC)},
        {2'b00, 16'hFF7F, 8'(PC)}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] kind, input logic [15:0] wdata, input int dur, input bit intrude);
        int  n = 0;
        int  dones = 0;
        bit  pol;
        logic [15:0] exp_w;
        pol = (kind == 2'b00) ? ~wdata[7] : 1'b0;
        @(negedge clk);
        op_start = 1'b1; op_kind = kind; op_wdata = wdata;
        @(negedge clk);
        op_start = 1'b0;
        while (busy && n < 64) begin
            exp_w = 16'h0000;
            exp_w[7] = pol;
            exp_w[6] = tgl_exp;
            check(rd_data == exp_w, "R5/R6/R7/R9 busy word", rd_data, exp_w);
            check(op_done == (n == dur - 1), "R3 done timing", op_done, (n == dur - 1));
            if (op_done) dones++;
            arr_rdata = arr_rdata + 16'h1357;
            op_wdata = ~op_wdata;                      // R5 later data ignored
            rd_stb = (n % 3) != 1;
            if (rd_stb) tgl_exp = ~tgl_exp;            // R7
            op_start = intrude && (n == 1);            // R4
            op_kind = 2'b11;
            n++;
            @(negedge clk);
            op_start = 1'b0;
        end
        rd_stb = 1'b0;
        check(n == dur, "R2 busy length", n, dur);
        check(dones == 1, "R3 single done", dones, 1);
        check(rd_data == arr_rdata, "R10 idle passthrough", rd_data, arr_rdata);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #3;
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 idle busy", busy, 0);
        check(op_done == 1'b0, "R1 idle done", op_done, 0);
        check(rd_data == arr_rdata, "R1 R10 reset passthrough", rd_data, arr_rdata);

        for (int i = 0; i < 6; i++) begin
            run_op(VEC[i][25:24], VEC[i][23:8], int'(VEC[i][7:0]), 1'b0);
            // R8 idle reads must not move the toggle bit
            for (int k = 0; k < 3; k++) begin
                rd_stb = 1'b1;
                arr_rdata = 16'h0F0F ^ 16'(k * 16'h1111 + i);
                @(negedge clk);
                check(rd_data == arr_rdata, "R10 idle read", rd_data, arr_rdata);
                check(busy == 1'b0, "R8 idle read keeps idle", busy, 0);
            end
            rd_stb = 1'b0;
        end

        // R4 start during program ignored: length stays PC, polarity stays program
        run_op(2'b00, 16'h0000, PC, 1'b1);
        // R4 start during sector erase ignored: length stays SC
        run_op(2'b01, 16'h0080, SC, 1'b1);

        // R8 reset restores TGL_INIT, idle start-free reset keeps idle
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        tgl_exp = 1'b0;
        run_op(2'b11, 16'h0000, CC, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule